// File: doc/BRIEF.md
# Matrix Tile Shape Configuration Unit

This unit keeps the shape settings for a bank of eight matrix tile registers. Software hands it a 64-byte configuration record in fixed-size beats. When the last beat has arrived, the unit checks the whole record. A good record replaces the active configuration in one step. A bad record raises a one-cycle fault pulse and changes nothing. A record whose palette is zero is a valid load that puts the unit into its init state and asks tile data storage to clear itself.

Downstream tile logic reads three things from the unit: a row count per tile, a bytes-per-row value per tile, and a flag that says a configuration is active. A release command also returns the unit to its init state. A readback command streams the active configuration out in the same beat format. When nothing is configured, the readback is all zeros.

Top module: `tilecfg_unit`

## Requirements
- R1: After reset, `cfg_valid`, all tile shapes, `fault`, `clear_req` and `rd_valid` are 0.
- R2: A record arrives as 64/BEAT_BYTES beats of BEAT_BYTES bytes, with the lowest-addressed bytes first. A beat with `ld_first` set is always placed at byte 0, which drops any partial record. A partial record never commits.
- R3: Record layout: byte 0 is the palette and bytes 1–15 are reserved. Tile t has its bytes-per-row at bytes 16+2t and 17+2t (little-endian) and its row count at byte 48+t. A palette-1 record that passes every check sets `cfg_valid` to 1 and loads the shapes. The rising edge that accepts the final beat has no effect on the outputs; the next rising edge updates them.
- R4: With palette 1, the record faults if any of these holds: a reserved byte is nonzero; a used tile has more than 16 rows; a used tile has more than 64 bytes per row; a used tile has a bytes-per-row that is not a multiple of 4; a used tile exceeds 1024 bytes; or tiles 8–15 have any nonzero field. A palette other than 0 or 1 also faults. On a fault, `fault` pulses for one cycle at the time a commit would have happened, and the state before the load is kept.
- R5: A palette-0 record, whatever its other bytes hold, clears `cfg_valid` and all shapes and pulses `clear_req` for one cycle. It does not raise `fault`.
- R6: `rel_req` clears `cfg_valid` and all shapes and pulses `clear_req` on the following edge. It also drops any partly received record.
- R7: A tile whose row count or bytes-per-row is zero is exported with both values zero.
- R8: An accepted `rd_req` produces exactly 64/BEAT_BYTES beats with `rd_valid` set, starting in the cycle after acceptance. When configured, the image has palette 1, each tile's exported shape in the R3 layout, and all other bytes zero.
- R9: A readback while unconfigured returns only zero data.
- R10: A `rd_req` that arrives while a readback is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A record beat is present |
| ld_first | input | 1 | This beat is byte 0 of a record |
| ld_data | input | BEAT_BYTES*8 | Record beat, lowest byte in bits 7:0 |
| rel_req | input | 1 | Release command |
| rd_req | input | 1 | Start a readback |
| rd_valid | output | 1 | A readback beat is present |
| rd_data | output | BEAT_BYTES*8 | Readback beat |
| cfg_valid | output | 1 | A configuration is active |
| tile_rows | output | NUM_TILES*ROW_W | Row count per tile, tile 0 in the low field |
| tile_bpr | output | NUM_TILES*BPR_W | Bytes per row per tile, tile 0 in the low field |
| fault | output | 1 | One-cycle pulse: record rejected |
| clear_req | output | 1 | One-cycle pulse: clear tile data |

## Verification
The bench drives the unit at each limit and just past it:
- 16 rows against 17 rows.
- 64 bytes per row against 66, and a bytes-per-row of 6 that is not a multiple of 4.
- A stray reserved byte.
- A stray field in one of tiles 8–15.
- An unknown palette.

A unit that checked only part of the record would commit some of these bad records. A unit that was not atomic would leave half-updated shapes behind after a fault.

The bench also covers several sequencing cases:
- A palette-0 record full of junk. A unit that validated it would fault instead of clearing.
- A release in the middle of a load, followed by a few stray beats. A unit that kept the beat index would commit a stitched-together record.
- A restart marked by `ld_first`.
- A tile with only one of its two fields zero. It must read back as fully zero.
- Readbacks while unconfigured, and a duplicate `rd_req` during a readback. A wrong unit would stream the stale configuration or extra beats.

// File: rtl/tilecfg_unit.sv
module tilecfg_unit #(
  parameter int NUM_TILES      = 8,
  parameter int MAX_ROWS       = 16,
  parameter int MAX_BPR        = 64,
  parameter int MAX_TILE_BYTES = 1024,
  parameter int BEAT_BYTES     = 8,
  localparam int ROW_W     = $clog2(MAX_ROWS + 1),
  localparam int BPR_W     = $clog2(MAX_BPR + 1),
  localparam int BEAT_BITS = BEAT_BYTES * 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_valid,
  input  logic                         ld_first,
  input  logic [BEAT_BITS-1:0]         ld_data,
  input  logic                         rel_req,
  input  logic                         rd_req,
  output logic                         rd_valid,
  output logic [BEAT_BITS-1:0]         rd_data,
  output logic                         cfg_valid,
  output logic [NUM_TILES*ROW_W-1:0]   tile_rows,
  output logic [NUM_TILES*BPR_W-1:0]   tile_bpr,
  output logic                         fault,
  output logic                         clear_req
);
  localparam int REC_BITS = 512;
  localparam int FIELDS   = 16;
  localparam int NBEATS   = 64 / BEAT_BYTES;
  localparam int IDX_W    = (NBEATS > 1) ? $clog2(NBEATS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBEATS - 1);

  // beat capture
  logic [NBEATS-1:0][BEAT_BITS-1:0] stg;
  logic [REC_BITS-1:0]              rec;
  logic [IDX_W-1:0]                 ld_idx, slot;
  logic                             pend;

  assign slot = ld_first ? '0 : ld_idx;
  assign rec  = stg;

  always_ff @(posedge clk) begin
    if (!rst_n || rel_req) begin
      ld_idx <= '0;
      pend   <= 1'b0;
    end else begin
      pend <= 1'b0;
      if (ld_valid) begin
        if (slot == LAST) begin
          pend   <= 1'b1;
          ld_idx <= '0;
        end else begin
          ld_idx <= slot + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (ld_valid && !rel_req) stg[slot] <= ld_data;

  // whole-record check
  logic [7:0]                       pal;
  logic                             bad;
  logic [NUM_TILES-1:0][ROW_W-1:0]  nrows;
  logic [NUM_TILES-1:0][BPR_W-1:0]  nbpr;

  assign pal = rec[7:0];

  always_comb begin
    bad   = (rec[127:8] != '0);
    nrows = '0;
    nbpr  = '0;
    for (int t = 0; t < FIELDS; t++) begin
      logic [15:0] b;
      logic [7:0]  r;
      b = rec[128 + 16*t +: 16];
      r = rec[384 + 8*t +: 8];
      if (t < NUM_TILES) begin
        if (32'(r) > MAX_ROWS || 32'(b) > MAX_BPR || b[1:0] != 2'b00 ||
            32'(r) * 32'(b) > MAX_TILE_BYTES)
          bad = 1'b1;
        else if (r != 8'd0 && b != 16'd0) begin
          nrows[t] = ROW_W'(r);
          nbpr[t]  = BPR_W'(b);
        end
      end else if (r != 8'd0 || b != 16'd0) begin
        bad = 1'b1;
      end
    end
  end

  // committed state
  logic [NUM_TILES-1:0][ROW_W-1:0] rows_q;
  logic [NUM_TILES-1:0][BPR_W-1:0] bpr_q;

  assign tile_rows = rows_q;
  assign tile_bpr  = bpr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      rows_q    <= '0;
      bpr_q     <= '0;
      fault     <= 1'b0;
      clear_req <= 1'b0;
    end else begin
      fault     <= 1'b0;
      clear_req <= 1'b0;
      if (rel_req || (pend && pal == 8'd0)) begin
        cfg_valid <= 1'b0;
        rows_q    <= '0;
        bpr_q     <= '0;
        clear_req <= 1'b1;
      end else if (pend) begin
        if (pal == 8'd1 && !bad) begin
          cfg_valid <= 1'b1;
          rows_q    <= nrows;
          bpr_q     <= nbpr;
        end else begin
          fault <= 1'b1;
        end
      end
    end
  end

  // readback
  logic [REC_BITS-1:0] img;
  logic [IDX_W-1:0]    rd_idx;
  logic                rd_busy;

  always_comb begin
    img = '0;
    if (cfg_valid) begin
      img[7:0] = 8'd1;
      for (int t = 0; t < NUM_TILES; t++) begin
        img[128 + 16*t +: 16] = 16'(bpr_q[t]);
        img[384 + 8*t +: 8]   = 8'(rows_q[t]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      rd_idx  <= '0;
    end else if (rd_busy) begin
      if (rd_idx == LAST) begin
        rd_busy <= 1'b0;
        rd_idx  <= '0;
      end else begin
        rd_idx <= rd_idx + IDX_W'(1);
      end
    end else if (rd_req) begin
      rd_busy <= 1'b1;
      rd_idx  <= '0;
    end
  end

  assign rd_valid = rd_busy;
  assign rd_data  = img[rd_idx*BEAT_BITS +: BEAT_BITS];

  // checks
  p_fault_keeps_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (cfg_valid == $past(cfg_valid) && rows_q == $past(rows_q) && bpr_q == $past(bpr_q)));

  p_fault_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_fault_not_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && clear_req));

  p_clear_is_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |-> (!cfg_valid && tile_rows == '0 && tile_bpr == '0));

  p_rd_unconf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cfg_valid) |-> rd_data == '0);

  p_shapes_need_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (tile_rows == '0 && tile_bpr == '0));

  for (genvar g = 0; g < NUM_TILES; g++) begin : g_tile_chk
    p_pair_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rows_q[g] == '0) == (bpr_q[g] == '0));
    p_limits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rows_q[g]) <= MAX_ROWS && 32'(bpr_q[g]) <= MAX_BPR && bpr_q[g][1:0] == 2'b00));
  end
endmodule

// File: tb/tilecfg_unit_bench.sv
module tilecfg_unit_bench;
  localparam int NT = 8, ROW_W = 5, BPR_W = 7, BB = 8, NB = 64 / BB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, ld_first = 0, rel_req = 0, rd_req = 0;
  logic [BB*8-1:0] ld_data = '0;
  logic rd_valid, cfg_valid, fault, clear_req;
  logic [BB*8-1:0] rd_data;
  logic [NT*ROW_W-1:0] tile_rows;
  logic [NT*BPR_W-1:0] tile_bpr;

  tilecfg_unit u_tilecfg_unit (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_first(ld_first), .ld_data(ld_data),
    .rel_req(rel_req), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_valid(cfg_valid), .tile_rows(tile_rows), .tile_bpr(tile_bpr),
    .fault(fault), .clear_req(clear_req));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected model
  bit exp_valid = 0;
  int exp_rows[NT], exp_bpr[NT];
  int w_rows[16], w_bpr[16];

  function automatic logic [511:0] build(input logic [7:0] pal);
    logic [511:0] r = '0;
    r[7:0] = pal;
    for (int t = 0; t < 16; t++) begin
      r[128 + 16*t +: 16] = 16'(w_bpr[t]);
      r[384 + 8*t +: 8]   = 8'(w_rows[t]);
    end
    return r;
  endfunction

  task automatic clear_w();
    for (int t = 0; t < 16; t++) begin w_rows[t] = 0; w_bpr[t] = 0; end
  endtask

  // kind: 0 commit, 1 fault, 2 init
  function automatic int model(input logic [511:0] r);
    bit ok;
    int rr, bb;
    if (r[7:0] == 8'd0) begin
      exp_valid = 0;
      for (int t = 0; t < NT; t++) begin exp_rows[t] = 0; exp_bpr[t] = 0; end
      return 2;
    end
    ok = (r[7:0] == 8'd1) && (r[127:8] == '0);
    for (int t = 0; t < 16; t++) begin
      rr = int'(r[384 + 8*t +: 8]);
      bb = int'(r[128 + 16*t +: 16]);
      if (t >= NT) begin
        if (rr != 0 || bb != 0) ok = 0;
      end else if (rr > 16 || bb > 64 || (bb % 4) != 0 || rr * bb > 1024) ok = 0;
    end
    if (!ok) return 1;
    exp_valid = 1;
    for (int t = 0; t < NT; t++) begin
      rr = int'(r[384 + 8*t +: 8]);
      bb = int'(r[128 + 16*t +: 16]);
      exp_rows[t] = (rr == 0 || bb == 0) ? 0 : rr;
      exp_bpr[t]  = (rr == 0 || bb == 0) ? 0 : bb;
    end
    return 0;
  endfunction

  task automatic check_state(input string req);
    chk({req, " cfg_valid"}, 64'(cfg_valid), 64'(exp_valid));
    for (int t = 0; t < NT; t++) begin
      chk({req, " rows"}, 64'(tile_rows[t*ROW_W +: ROW_W]), 64'(exp_rows[t]));
      chk({req, " bpr"},  64'(tile_bpr[t*BPR_W +: BPR_W]),  64'(exp_bpr[t]));
    end
  endtask

  task automatic beat(input logic first, input logic [BB*8-1:0] d);
    @(negedge clk);
    ld_valid = 1; ld_first = first; ld_data = d;
  endtask

  task automatic load(input logic [511:0] r, input string req);
    int kind;
    for (int b = 0; b < NB; b++) beat(b == 0, r[b*BB*8 +: BB*8]);
    @(negedge clk);
    ld_valid = 0; ld_first = 0;
    chk({req, " no early commit"}, 64'(fault | clear_req), 64'(0));
    @(negedge clk);
    kind = model(r);
    chk({req, " fault"}, 64'(fault), 64'(kind == 1));
    chk({req, " clear_req"}, 64'(clear_req), 64'(kind == 2));
    check_state(req);
    @(negedge clk);
    chk({req, " pulse ends"}, 64'(fault | clear_req), 64'(0));
  endtask

  // scoreboard
  logic [BB*8-1:0] sb_q[$];
  string rd_tag = "R8";

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected beat actual=%h expected=none", rd_tag, rd_data);
      end else begin
        logic [BB*8-1:0] e;
        e = sb_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s readback actual=%h expected=%h", rd_tag, rd_data, e);
        end
      end
    end
  end

  task automatic readback(input string req, input int hold);
    logic [511:0] img = '0;
    rd_tag = req;
    if (exp_valid) begin
      img[7:0] = 8'd1;
      for (int t = 0; t < NT; t++) begin
        img[128 + 16*t +: 16] = 16'(exp_bpr[t]);
        img[384 + 8*t +: 8]   = 8'(exp_rows[t]);
      end
    end
    for (int b = 0; b < NB; b++) sb_q.push_back(img[b*BB*8 +: BB*8]);
    @(negedge clk);
    rd_req = 1;
    repeat (hold) @(negedge clk);
    rd_req = 0;
    repeat (NB + 2) @(negedge clk);
    chk({req, " all beats consumed"}, 64'(sb_q.size()), 64'(0));
  endtask

  task automatic release_check(input string req);
    @(negedge clk);
    rel_req = 1;
    @(negedge clk);
    rel_req = 0;
    void'(model('0));
    chk({req, " clear_req"}, 64'(clear_req), 64'(1));
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] ra, rb, r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 fault", 64'(fault), 0);
    chk("R1 clear_req", 64'(clear_req), 0);
    chk("R1 rd_valid", 64'(rd_valid), 0);
    check_state("R1");

    // R9 unconfigured readback
    readback("R9", 1);

    // R3 / R7 valid record with boundaries
    clear_w();
    w_rows[0] = 16; w_bpr[0] = 64;
    w_rows[1] = 1;  w_bpr[1] = 4;
    w_rows[2] = 7;  w_bpr[2] = 20;
    w_rows[3] = 5;  w_bpr[3] = 0;
    w_rows[4] = 0;  w_bpr[4] = 32;
    w_rows[7] = 12; w_bpr[7] = 48;
    ra = build(8'd1);
    load(ra, "R3 R7");
    readback("R8", 1);

    // R4 faults, state must stay as ra
    w_bpr[2] = 66;  load(build(8'd1), "R4 bpr over");
    w_bpr[2] = 20;  w_rows[1] = 17; load(build(8'd1), "R4 rows over");
    w_rows[1] = 1;  w_bpr[5] = 6; w_rows[5] = 2; load(build(8'd1), "R4 bpr align");
    w_bpr[5] = 0;   w_rows[5] = 0;
    w_rows[9] = 3;  load(build(8'd1), "R4 upper tile");
    w_rows[9] = 0;
    r = build(8'd1); r[7*8 +: 8] = 8'h5A; load(r, "R4 reserved");
    load(build(8'd2), "R4 palette");
    check_state("R4 kept");

    // R2 ld_first realigns after partial junk
    beat(1, 64'hFFFF_FFFF_FFFF_FFFF);
    beat(0, 64'hFFFF_FFFF_FFFF_FFFF);
    beat(0, 64'hFFFF_FFFF_FFFF_FFFF);
    clear_w();
    w_rows[6] = 3; w_bpr[6] = 8;
    rb = build(8'd1);
    load(rb, "R2 realign");

    // R5 palette zero with junk
    r = '1; r[7:0] = 8'd0;
    load(r, "R5");
    readback("R9 after init", 1);

    // R6 release, including mid-load
    load(ra, "R3 reload");
    release_check("R6 release");
    load(rb, "R3 reload b");
    for (int b = 0; b < 3; b++) beat(b == 0, rb[b*64 +: 64]);
    @(negedge clk);
    ld_valid = 0; ld_first = 0;
    release_check("R6 mid-load");
    for (int b = 3; b < NB; b++) beat(0, rb[b*64 +: 64]);
    @(negedge clk);
    ld_valid = 0;
    repeat (2) @(negedge clk);
    chk("R6 partial no commit", 64'(cfg_valid), 0);
    chk("R6 partial no fault", 64'(fault), 0);

    // R10 duplicate request during readback
    load(ra, "R3 final");
    readback("R10", 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule